// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block is the coherence agent of one node on a shared broadcast bus. It fronts a small direct-mapped write-back cache that holds one data word per line. Every line is in one of three states: invalid, shared (clean and readable), or exclusive (dirty, writable, and the only copy in the system). The processor side issues one read or write at a time. Hits finish in the same cycle. A miss raises a stall, requests the bus, and places a read-miss or write-miss transaction on it. A write to a shared line is also sent to the bus as a write miss. If the line being replaced is dirty, a write-back transaction goes out first.

The block also watches every transaction that other nodes put on the bus. A snooped read miss that hits an exclusive line is answered by this node in the following cycle: it drives the line data and raises an abort so that memory stays silent, and the line drops to shared. A snooped write miss that hits the line invalidates it. If the line was exclusive, the node also supplies the dirty data with an abort first. Snoops always win over a local request that has not yet been accepted on the bus. Because the bus carries one transaction at a time, it serializes all writes to any location.

The state machine has three states. IDLE serves hits and takes new requests. ARB holds the bus request: when the grant arrives, it issues either a write-back (and stays in ARB) or the miss (and moves to RESP). RESP waits for the response data, fills the line, releases the processor, and returns to IDLE. The transitions are IDLE to ARB on a miss, ARB to ARB after a write-back, ARB to RESP when the miss is issued, and RESP to IDLE when the response arrives.

Top module: `snoop_wb_coh`

## Requirements
- R1: After reset every line is invalid, and cpu_stall, bus_req, bus_cmd and snp_abort are all zero. The first access to any address is therefore a miss.
- R2: A processor read that hits a shared or exclusive line with a matching tag returns the line data with cpu_stall low in the same cycle and produces no bus transaction.
- R3: A processor read miss raises bus_req. When granted, it drives bus_cmd = 1 (read miss) with the full address on bus_addr. It returns bus_rdata on cpu_rdata and fills the line as shared.
- R4: A processor write to an invalid line, a non-matching line, or a shared line drives bus_cmd = 2 (write miss) with the full address. The line then holds the written data in the exclusive state.
- R5: A processor write that hits an exclusive line is performed locally with cpu_stall low and no bus transaction.
- R6: A miss that displaces an exclusive line first drives bus_cmd = 3 (write-back), with the victim address ({stored tag, index}) and the dirty data, and then issues the miss. Displacing a shared or invalid line causes no write-back.
- R7: A snooped read miss (snp_cmd = 1) that hits an exclusive line makes snp_abort high, with the line data on snp_data, in the next cycle. The line becomes shared.
- R8: A snooped write miss (snp_cmd = 2) that hits a shared or exclusive line invalidates it. If the line was exclusive, snp_abort and snp_data supply its data in the next cycle.
- R9: A snooped read miss to a shared line, any snoop whose tag misses, and a snooped write-back (snp_cmd = 3) leave the line unchanged and keep snp_abort low.
- R10: A snoop has priority: while snp_valid is high, a local hit does not complete and a bus grant is not taken. Line state is evaluated at the grant, so a victim that a snoop has cleaned needs no write-back.
- R11: Only one processor request is outstanding. cpu_stall stays high from a miss until the cycle in which bus_rvalid returns the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until cpu_stall is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address, with the index in the low INDEX_W bits |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when cpu_stall is low |
| cpu_stall | output | 1 | High while a request is waiting |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rvalid | input | 1 | Response to this node's miss is valid |
| bus_rdata | input | DATA_W | Response data |
| snp_valid | input | 1 | Another node's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | This node supplies data; memory must not respond |
| snp_data | output | DATA_W | Supplied dirty data |

## Verification
The bench builds the block with ADDR_W = 4, INDEX_W = 2 and DATA_W = 8. This gives four lines and four tags per line, so every one of the sixteen addresses can be read, written and snooped in each line state. Each line meets every kind of conflict eviction: shared replaced silently, and exclusive replaced through a write-back. A bench model of the line states and the memory predicts every bus command, address, data word and abort. Two dedicated sequences check the snoop-priority cases: a snoop that arrives together with the grant, and a snoop that arrives together with a local hit.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/coh_array.sv
module coh_array
    import coh_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 5,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] ra_idx,
    output line_st_t           ra_st,
    output logic [TAG_W-1:0]   ra_tag,
    output logic [DATA_W-1:0]  ra_data,
    input  logic [INDEX_W-1:0] rb_idx,
    output line_st_t           rb_st,
    output logic [TAG_W-1:0]   rb_tag,
    output logic [DATA_W-1:0]  rb_data,
    input  logic               lw_en,
    input  logic [INDEX_W-1:0] lw_idx,
    input  line_st_t           lw_st,
    input  logic [TAG_W-1:0]   lw_tag,
    input  logic [DATA_W-1:0]  lw_data,
    input  logic               sw_en,
    input  logic [INDEX_W-1:0] sw_idx,
    input  line_st_t           sw_st
);
    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        line_st_t              st;
        logic [TAG_W-1:0]      tag;
        logic [DATA_W-1:0]     data;
    } line_t;

    line_t lines_w [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '{st: LN_INV, tag: '0, data: '0};
            end else begin
                if (lw_en && lw_idx == INDEX_W'(g))
                    q <= '{st: lw_st, tag: lw_tag, data: lw_data};
                // snoop update is applied last and therefore wins
                if (sw_en && sw_idx == INDEX_W'(g))
                    q.st <= sw_st;
            end
        end
        assign lines_w[g] = q;
    end

    assign ra_st   = lines_w[ra_idx].st;
    assign ra_tag  = lines_w[ra_idx].tag;
    assign ra_data = lines_w[ra_idx].data;
    assign rb_st   = lines_w[rb_idx].st;
    assign rb_tag  = lines_w[rb_idx].tag;
    assign rb_data = lines_w[rb_idx].data;
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              sw_en,
    output line_st_t          sw_st,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    logic ln_hit;
    logic supply;

    assign ln_hit = (ln_st != LN_INV) && (ln_tag == snp_tag);

    always_comb begin
        sw_en  = 1'b0;
        sw_st  = ln_st;
        supply = 1'b0;
        if (snp_valid && ln_hit) begin
            unique case (snp_cmd)
                2'(BC_RDMISS): begin
                    if (ln_st == LN_EXC) begin
                        sw_en  = 1'b1;
                        sw_st  = LN_SHR;
                        supply = 1'b1;
                    end
                end
                2'(BC_WRMISS): begin
                    sw_en  = 1'b1;
                    sw_st  = LN_INV;
                    supply = (ln_st == LN_EXC);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_abort <= 1'b0;
            snp_data  <= '0;
        end else begin
            snp_abort <= supply;
            snp_data  <= supply ? ln_data : '0;
        end
    end

    // R7
    rd_owner_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'(BC_RDMISS) && ln_hit && ln_st == LN_EXC) |=> snp_abort);

    // R9
    abort_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> $past(snp_valid) && $past(snp_cmd) != 2'(BC_WBACK));
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 3,
    parameter int DATA_W  = 16,
    localparam int TAG_W  = ADDR_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_stall,
    input  line_st_t           ln_st,
    input  logic [TAG_W-1:0]   ln_tag,
    input  logic [DATA_W-1:0]  ln_data,
    input  logic               snp_valid,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rvalid,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               lw_en,
    output line_st_t           lw_st,
    output logic [TAG_W-1:0]   lw_tag,
    output logic [DATA_W-1:0]  lw_data
);
    typedef enum logic [1:0] {S_IDLE, S_ARB, S_RESP} fsm_t;

    fsm_t state, state_nx;
    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic tag_eq, hit_now, victim_dirty, grant_ok;

    assign req_tag      = cpu_addr[ADDR_W-1:INDEX_W];
    assign req_idx      = cpu_addr[INDEX_W-1:0];
    assign tag_eq       = (ln_st != LN_INV) && (ln_tag == req_tag);
    assign hit_now      = tag_eq && (!cpu_we || ln_st == LN_EXC);
    assign victim_dirty = (ln_st == LN_EXC) && (ln_tag != req_tag);
    assign grant_ok     = bus_gnt && !snp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (cpu_req && !snp_valid && !hit_now) state_nx = S_ARB;
            S_ARB:  if (grant_ok && !victim_dirty)         state_nx = S_RESP;
            S_RESP: if (bus_rvalid)                        state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        cpu_stall = 1'b0;
        cpu_rdata = ln_data;
        bus_req   = 1'b0;
        bus_cmd   = 2'(BC_NONE);
        bus_addr  = '0;
        bus_wdata = '0;
        lw_en     = 1'b0;
        lw_st     = ln_st;
        lw_tag    = ln_tag;
        lw_data   = ln_data;
        unique case (state)
            S_IDLE: begin
                cpu_stall = cpu_req && (snp_valid || !hit_now);
                if (cpu_req && !snp_valid && hit_now && cpu_we) begin
                    lw_en   = 1'b1;
                    lw_st   = LN_EXC;
                    lw_data = cpu_wdata;
                end
            end
            S_ARB: begin
                cpu_stall = 1'b1;
                bus_req   = 1'b1;
                if (grant_ok) begin
                    if (victim_dirty) begin
                        bus_cmd   = 2'(BC_WBACK);
                        bus_addr  = {ln_tag, req_idx};
                        bus_wdata = ln_data;
                        lw_en     = 1'b1;
                        lw_st     = LN_INV;
                    end else begin
                        bus_cmd   = cpu_we ? 2'(BC_WRMISS) : 2'(BC_RDMISS);
                        bus_addr  = cpu_addr;
                        bus_wdata = cpu_wdata;
                    end
                end
            end
            S_RESP: begin
                cpu_stall = !bus_rvalid;
                cpu_rdata = bus_rdata;
                if (bus_rvalid) begin
                    lw_en   = 1'b1;
                    lw_st   = cpu_we ? LN_EXC : LN_SHR;
                    lw_tag  = req_tag;
                    lw_data = cpu_we ? cpu_wdata : bus_rdata;
                end
            end
            default: ;
        endcase
    end

    // R10
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> bus_cmd == 2'(BC_NONE));

    // R11
    cmd_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd != 2'(BC_NONE) |-> bus_gnt && cpu_stall);

    // R6
    wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'(BC_WBACK) |=> bus_req && cpu_stall);

    // R11
    resp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'(BC_RDMISS) || bus_cmd == 2'(BC_WRMISS)) |=> !bus_req);
endmodule

// File: rtl/snoop_wb_coh.sv
module snoop_wb_coh
    import coh_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    line_st_t           ca_st, sn_st, lw_st, sw_st;
    logic [TAG_W-1:0]   ca_tag, sn_tag, lw_tag;
    logic [DATA_W-1:0]  ca_data, sn_data, lw_data;
    logic               lw_en, sw_en;

    coh_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk, .rst_n,
        .ra_idx(cpu_addr[INDEX_W-1:0]), .ra_st(ca_st), .ra_tag(ca_tag), .ra_data(ca_data),
        .rb_idx(snp_addr[INDEX_W-1:0]), .rb_st(sn_st), .rb_tag(sn_tag), .rb_data(sn_data),
        .lw_en, .lw_idx(cpu_addr[INDEX_W-1:0]), .lw_st, .lw_tag, .lw_data,
        .sw_en, .sw_idx(snp_addr[INDEX_W-1:0]), .sw_st
    );

    coh_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .clk, .rst_n, .snp_valid, .snp_cmd,
        .snp_tag(snp_addr[ADDR_W-1:INDEX_W]),
        .ln_st(sn_st), .ln_tag(sn_tag), .ln_data(sn_data),
        .sw_en, .sw_st, .snp_abort, .snp_data
    );

    coh_req_fsm #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_fsm (
        .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_stall,
        .ln_st(ca_st), .ln_tag(ca_tag), .ln_data(ca_data), .snp_valid,
        .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_rvalid, .bus_rdata,
        .lw_en, .lw_st, .lw_tag, .lw_data
    );
endmodule

// File: tb/snoop_wb_coh_tb_top.sv
module snoop_wb_coh_tb_top;
    localparam int AW = 4, IW = 2, DW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_rvalid = 0, snp_valid = 0;
    logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, bus_rdata = '0;
    logic [1:0] snp_cmd = '0;
    logic [DW-1:0] cpu_rdata, bus_wdata, snp_data;
    logic [AW-1:0] bus_addr;
    logic [1:0] bus_cmd;
    logic cpu_stall, bus_req, snp_abort;

    int n_chk = 0, n_err = 0;
    int m_st [4];
    int m_tag [4];
    int m_data [4];
    int mem [16];

    always #10 clk = ~clk;

    snoop_wb_coh #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // response phase of an accepted miss
    task automatic finish_miss(input bit we, input int a, input int wd);
        @(negedge clk); bus_gnt = 0; #1;
        chk("R11 stall held before response", cpu_stall, 1);
        @(negedge clk); bus_rvalid = 1; bus_rdata = DW'(mem[a]); #1;
        chk("R11 stall released with response", cpu_stall, 0);
        if (!we) chk("R3 read miss data", cpu_rdata, mem[a]);
        @(negedge clk); bus_rvalid = 0; cpu_req = 0;
        m_st[a%4] = we ? 2 : 1; m_tag[a%4] = a/4; m_data[a%4] = we ? wd : mem[a];
    endtask

    task automatic cpu_op(input bit we, input int a, input int wd);
        int idx = a % 4, tg = a / 4;
        bit hit = m_st[idx] != 0 && m_tag[idx] == tg && (!we || m_st[idx] == 2);
        @(negedge clk); cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd); #1;
        if (hit) begin
            chk(we ? "R5 write hit no stall" : "R2 read hit no stall", cpu_stall, 0);
            if (!we) chk("R2 read hit data", cpu_rdata, m_data[idx]);
            @(negedge clk); cpu_req = 0; #1;
            chk(we ? "R5 no bus request" : "R2 no bus request", bus_req, 0);
            if (we) m_data[idx] = wd;
        end else begin
            chk("R11 miss stalls", cpu_stall, 1);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk("R3 bus request on miss", bus_req, 1);
                bus_gnt = 1; #1;
                if (m_st[idx] == 2 && m_tag[idx] != tg) begin
                    chk("R6 write-back cmd", bus_cmd, 3);
                    chk("R6 write-back addr", bus_addr, m_tag[idx] * 4 + idx);
                    chk("R6 write-back data", bus_wdata, m_data[idx]);
                    mem[m_tag[idx] * 4 + idx] = m_data[idx];
                    m_st[idx] = 0;
                end else begin
                    chk(m_st[idx] == 1 && m_tag[idx] != tg ? "R6 shared evict no write-back"
                        : (we ? "R4 write miss cmd" : "R3 read miss cmd"), bus_cmd, we ? 2 : 1);
                    chk(we ? "R4 miss addr" : "R3 miss addr", bus_addr, a);
                    break;
                end
            end
            finish_miss(we, a, wd);
        end
    endtask

    task automatic snoop(input int cmd, input int a);
        int idx = a % 4, tg = a / 4;
        bit hit = m_st[idx] != 0 && m_tag[idx] == tg;
        bit sup = hit && m_st[idx] == 2 && (cmd == 1 || cmd == 2);
        string lbl = (cmd == 1 && sup) ? "R7 read snoop of owner"
                   : (cmd == 2 && hit) ? "R8 write snoop invalidates" : "R9 snoop no effect";
        @(negedge clk); snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = AW'(a);
        @(negedge clk); snp_valid = 0; #1;
        chk(lbl, snp_abort, sup);
        if (sup) begin
            chk(lbl, snp_data, m_data[idx]);
            mem[a] = m_data[idx];
        end
        if (hit && cmd == 2) m_st[idx] = 0;
        else if (sup) m_st[idx] = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = 0; end
        for (int i = 0; i < 16; i++) mem[i] = (i * 13 + 1) % 256;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset stall", cpu_stall, 0);
        chk("R1 reset bus_req", bus_req, 0);
        chk("R1 reset bus_cmd", bus_cmd, 0);
        chk("R1 reset abort", snp_abort, 0);

        // R1 R3 R6: read sweeps, every first access misses, shared evictions silent
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < 16; a++) cpu_op(0, a, 0);
        for (int a = 12; a < 16; a++) cpu_op(0, a, 0);           // R2 hits
        // R4 R6: write sweep over shared and dirty victims
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < 16; a++) cpu_op(1, a, (a * 37 + r * 11 + 5) % 256);
        for (int a = 12; a < 16; a++) begin
            cpu_op(1, a, (a * 19 + 3) % 256);                   // R5
            cpu_op(0, a, 0);                                    // R2 on exclusive
        end
        // R7 R8 R9: snoop sweep
        for (int a = 0; a < 16; a++) begin
            cpu_op(1, a, (a * 29 + 7) % 256);
            snoop(1, a);
            cpu_op(0, a, 0);
            snoop(1, a);
            snoop(2, a);
            cpu_op(0, a, 0);
            cpu_op(1, a, (a * 5 + 9) % 256);
            snoop(3, a);
            snoop(1, (a + 4) % 16);
            snoop(2, (a + 8) % 16);
            cpu_op(0, a, 0);
            snoop(2, a);
        end

        // R10: snoop together with the grant cleans the victim, so no write-back
        cpu_op(1, 1, 8'h5A);
        @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = AW'(5); cpu_wdata = 8'hC3; #1;
        chk("R10 miss stalls", cpu_stall, 1);
        @(negedge clk); snp_valid = 1; snp_cmd = 2'd1; snp_addr = AW'(1); bus_gnt = 1; #1;
        chk("R10 grant ignored during snoop", bus_cmd, 0);
        @(negedge clk); snp_valid = 0; #1;
        chk("R10 snoop served first", snp_abort, 1);
        chk("R10 snoop data", snp_data, 8'h5A);
        mem[1] = 8'h5A; m_st[1] = 1;
        chk("R10 no write-back after clean", bus_cmd, 2);
        chk("R10 miss addr", bus_addr, 5);
        finish_miss(1, 5, 8'hC3);
        cpu_op(0, 5, 0);

        // R10: snoop in the same cycle as a local hit blocks the hit
        cpu_op(1, 2, 8'h77);
        @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = AW'(2);
        snp_valid = 1; snp_cmd = 2'd2; snp_addr = AW'(2); #1;
        chk("R10 local hit held during snoop", cpu_stall, 1);
        @(negedge clk); snp_valid = 0; cpu_req = 0; #1;
        chk("R10 snoop write served", snp_abort, 1);
        chk("R10 snoop write data", snp_data, 8'h77);
        mem[2] = 8'h77; m_st[2] = 0;
        cpu_op(0, 2, 0);                                        // R8: now misses

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule